// File: doc/BRIEF.md
# Iterative Long Multiply-Accumulate Unit

This unit forms the 64-bit product of two 32-bit operands, signed or unsigned, and can add a 64-bit accumulator supplied as a high/low word pair. The result comes back as a high word and a low word, together with the two destination register indices taken from the instruction word and optional negative/zero flag results. The surrounding pipeline supplies the instruction word and the four operand values already read from its register file, then pulses `start`. It waits for the one-cycle `done` strobe and writes the results back itself.

The multiplier retires `DIGIT_W` bits of the second operand per cycle, using a shift-and-add scheme in radix 2^`DIGIT_W`. In signed mode it multiplies the operand magnitudes and fixes the sign in a final cycle, where it also adds the accumulator and derives the flags. The controller has three states. `ST_IDLE` waits for work. `ST_MUL` runs the digit iterations. `ST_FIN` registers the results and raises `done`. There are four transitions. *accept* goes from `ST_IDLE` to `ST_MUL` when `start` is high. *step* keeps `ST_MUL` while iterations remain. *last* goes from `ST_MUL` to `ST_FIN` after the final digit. *retire* goes from `ST_FIN` back to `ST_IDLE`.

Top module: `lmac_unit`

## Requirements
- R1: At `done`, `dst_hi` equals instruction bits 19:16 and `dst_lo` equals instruction bits 15:12, as captured when the operation was accepted. No other instruction bits besides 22, 21 and 20 affect the result.
- R2: With instruction bit 22 clear, both operands are unsigned and the result is their full 64-bit product.
- R3: With instruction bit 22 set, both operands are two's-complement signed and the result is their 64-bit signed product.
- R4: With instruction bit 21 set, the 64-bit value {`acc_hi`,`acc_lo`} is added to the product, wrapping modulo 2^64.
- R5: `res_hi` carries result bits 63:32 and `res_lo` carries result bits 31:0.
- R6: With instruction bit 20 set, `flag_wr` is high at `done`, and `flag_z` is high only when both result words are zero.
- R7: With instruction bit 20 set, `flag_n` equals bit 31 of `res_hi` at `done`.
- R8: With instruction bit 20 clear, `flag_wr` stays low. `flag_wr` is never high outside a `done` cycle.
- R9: `done` is high for exactly one cycle. It is sampled high at the (32/`DIGIT_W`+2)-th rising edge after the edge that accepted `start`, which is edge 10 with the default `DIGIT_W` of 4. A new `start` is accepted on the edge right after `done` goes high.
- R10: A `start` that arrives while an operation is in flight is ignored. It produces no extra `done`, and the results are those of the operation already running.
- R11: After reset, `done`, `flag_wr` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| instr | input | 32 | Instruction word: destination indices and mode bits |
| op_m | input | 32 | First multiplicand |
| op_s | input | 32 | Second multiplicand |
| acc_hi | input | 32 | Accumulator high word |
| acc_lo | input | 32 | Accumulator low word |
| dst_hi | output | 4 | High destination register index |
| dst_lo | output | 4 | Low destination register index |
| res_hi | output | 32 | Result bits 63:32 |
| res_lo | output | 32 | Result bits 31:0 |
| flag_n | output | 1 | Negative flag result |
| flag_z | output | 1 | Zero flag result |
| flag_wr | output | 1 | Flags should be written (pulses with done) |
| done | output | 1 | One-cycle result-valid strobe |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before any `start`. They also assume that inputs change only between clock edges, so that the accepting edge and the latency count are well defined. The stimulus drives every input on the falling edge and holds reset for three cycles. It pulses `start` either while the unit is idle or, on purpose, while it is busy. It also holds `start` high across whole operations to exercise re-acceptance on the edge right after `done`.

// File: rtl/lmac_pkg.sv
package lmac_pkg;

    localparam int HI_IDX_LSB = 16;
    localparam int LO_IDX_LSB = 12;
    localparam int SIGNED_BIT = 22;
    localparam int ACCUM_BIT  = 21;
    localparam int FLAGS_BIT  = 20;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MUL,
        ST_FIN
    } lmac_state_e;

    typedef struct packed {
        logic [3:0]  hi_idx;
        logic [3:0]  lo_idx;
        logic        do_acc;
        logic        set_flags;
        logic        neg;
        logic [31:0] mag_m;
        logic [31:0] mag_s;
        logic [63:0] acc;
    } lmac_cmd_t;

endpackage

// File: rtl/lmac_decode.sv
module lmac_decode
    import lmac_pkg::*;
(
    input  logic [31:0] instr,
    input  logic [31:0] op_m,
    input  logic [31:0] op_s,
    input  logic [31:0] acc_hi,
    input  logic [31:0] acc_lo,
    output lmac_cmd_t   cmd
);
    logic is_signed;
    logic m_neg;
    logic s_neg;

    always_comb begin
        is_signed     = instr[SIGNED_BIT];
        m_neg         = is_signed & op_m[31];
        s_neg         = is_signed & op_s[31];
        cmd.hi_idx    = instr[HI_IDX_LSB +: 4];
        cmd.lo_idx    = instr[LO_IDX_LSB +: 4];
        cmd.do_acc    = instr[ACCUM_BIT];
        cmd.set_flags = instr[FLAGS_BIT];
        cmd.neg       = m_neg ^ s_neg;
        // magnitude of the most negative value is still correct as unsigned
        cmd.mag_m     = m_neg ? (~op_m + 32'd1) : op_m;
        cmd.mag_s     = s_neg ? (~op_s + 32'd1) : op_s;
        cmd.acc       = {acc_hi, acc_lo};
    end
endmodule

// File: rtl/lmac_iter.sv
module lmac_iter #(
    parameter int WORD_W  = 32,
    parameter int DIGIT_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  step,
    input  logic [WORD_W-1:0]     mag_m,
    input  logic [WORD_W-1:0]     mag_s,
    output logic [2*WORD_W-1:0]   prod
);
    localparam int PROD_W = 2 * WORD_W;

    logic [PROD_W-1:0] mcand;
    logic [WORD_W-1:0] mplier;
    logic [PROD_W-1:0] partial;

    generate
        if (DIGIT_W == 1) begin : g_radix2
            always_comb partial = mplier[0] ? mcand : '0;
        end else begin : g_radixn
            always_comb partial = mcand * {{(PROD_W-DIGIT_W){1'b0}}, mplier[DIGIT_W-1:0]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand  <= '0;
            mplier <= '0;
            prod   <= '0;
        end else if (load) begin
            mcand  <= {{WORD_W{1'b0}}, mag_m};
            mplier <= mag_s;
            prod   <= '0;
        end else if (step) begin
            prod   <= prod + partial;
            mcand  <= mcand << DIGIT_W;
            mplier <= mplier >> DIGIT_W;
        end
    end
endmodule

// File: rtl/lmac_finish.sv
module lmac_finish #(
    parameter int WORD_W = 32
) (
    input  logic [2*WORD_W-1:0] prod,
    input  logic                neg,
    input  logic                do_acc,
    input  logic [2*WORD_W-1:0] acc,
    output logic [2*WORD_W-1:0] result,
    output logic                is_neg,
    output logic                is_zero
);
    logic [2*WORD_W-1:0] signed_prod;

    always_comb begin
        signed_prod = neg ? (~prod + 1'b1) : prod;
        result      = signed_prod + (do_acc ? acc : '0);
        is_neg      = result[2*WORD_W-1];
        is_zero     = (result == '0);
    end
endmodule

// File: rtl/lmac_unit.sv
module lmac_unit
    import lmac_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int DIGIT_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] instr,
    input  logic [31:0] op_m,
    input  logic [31:0] op_s,
    input  logic [31:0] acc_hi,
    input  logic [31:0] acc_lo,
    output logic [3:0]  dst_hi,
    output logic [3:0]  dst_lo,
    output logic [31:0] res_hi,
    output logic [31:0] res_lo,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_wr,
    output logic        done
);
    localparam int ITERS = WORD_W / DIGIT_W;
    localparam int CNT_W = $clog2(ITERS + 1);

    lmac_state_e state, state_nx;
    lmac_cmd_t   cmd_in, cmd_q;
    logic [CNT_W-1:0] cnt;
    logic        accept, last;
    logic [63:0] prod, result;
    logic        r_neg, r_zero;

    lmac_decode u_decode (
        .instr (instr), .op_m (op_m), .op_s (op_s),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .cmd (cmd_in)
    );

    lmac_iter #(.WORD_W(WORD_W), .DIGIT_W(DIGIT_W)) u_iter (
        .clk  (clk), .rst_n(rst_n),
        .load (accept), .step(state == ST_MUL),
        .mag_m(cmd_in.mag_m), .mag_s(cmd_in.mag_s),
        .prod (prod)
    );

    lmac_finish #(.WORD_W(WORD_W)) u_finish (
        .prod (prod), .neg(cmd_q.neg), .do_acc(cmd_q.do_acc), .acc(cmd_q.acc),
        .result(result), .is_neg(r_neg), .is_zero(r_zero)
    );

    assign accept = (state == ST_IDLE) && start;
    assign last   = (cnt == CNT_W'(ITERS - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_MUL;   // accept
            ST_MUL:  if (last)  state_nx = ST_FIN;   // last / step
            ST_FIN:             state_nx = ST_IDLE;  // retire
            default:            state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cmd_q <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                cmd_q <= cmd_in;
                cnt   <= '0;
            end else if (state == ST_MUL) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_hi  <= '0;
            dst_lo  <= '0;
            res_hi  <= '0;
            res_lo  <= '0;
            flag_n  <= 1'b0;
            flag_z  <= 1'b0;
            flag_wr <= 1'b0;
            done    <= 1'b0;
        end else begin
            done    <= 1'b0;
            flag_wr <= 1'b0;
            if (state == ST_FIN) begin
                dst_hi  <= cmd_q.hi_idx;
                dst_lo  <= cmd_q.lo_idx;
                res_hi  <= result[63:32];
                res_lo  <= result[31:0];
                flag_n  <= r_neg;
                flag_z  <= r_zero;
                flag_wr <= cmd_q.set_flags;
                done    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lmac_unit_chk.sv
module lmac_unit_chk #(
    parameter int WORD_W  = 32,
    parameter int DIGIT_W = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [31:0] res_hi,
    input logic [31:0] res_lo,
    input logic        flag_n,
    input logic        flag_z,
    input logic        flag_wr,
    input logic        done
);
    localparam int ITERS = WORD_W / DIGIT_W;

    logic     busy_seen;
    int       since;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_seen <= 1'b0;
            since     <= 0;
        end else if (busy_seen && done) begin
            busy_seen <= start;
            since     <= 0;
        end else if (busy_seen) begin
            since <= since + 1;
        end else if (start) begin
            busy_seen <= 1'b1;
            since     <= 0;
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_seen && since == ITERS + 1));

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_wr) |-> (flag_z == (res_hi == 32'd0 && res_lo == 32'd0)));

    // R7
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_wr) |-> (flag_n == res_hi[31]));

    // R8
    flag_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |-> done);
endmodule

bind lmac_unit lmac_unit_chk #(.WORD_W(WORD_W), .DIGIT_W(DIGIT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .res_hi(res_hi), .res_lo(res_lo),
    .flag_n(flag_n), .flag_z(flag_z), .flag_wr(flag_wr), .done(done)
);

// File: tb/lmac_unit_bench.sv
module lmac_unit_bench;
    localparam int DIG   = 4;
    localparam int ITERS = 32 / DIG;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0, op_m = '0, op_s = '0, acc_hi = '0, acc_lo = '0;
    logic [3:0]  dst_hi, dst_lo;
    logic [31:0] res_hi, res_lo;
    logic        flag_n, flag_z, flag_wr, done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    int          rem = 0;
    bit          exp_done = 0;
    logic [63:0] exp_res;
    logic [7:0]  exp_idx;
    bit          exp_s;
    string       exp_tag;
    string       op_tag = "R2";

    always #4 clk = ~clk;

    lmac_unit #(.WORD_W(32), .DIGIT_W(DIG)) u_lmac_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .op_m(op_m), .op_s(op_s), .acc_hi(acc_hi), .acc_lo(acc_lo),
        .dst_hi(dst_hi), .dst_lo(dst_lo), .res_hi(res_hi), .res_lo(res_lo),
        .flag_n(flag_n), .flag_z(flag_z), .flag_wr(flag_wr), .done(done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [31:0] m, input logic [31:0] s,
                                          input logic [63:0] acc, input bit u, input bit a);
        logic [63:0] em, es;
        em = u ? {{32{m[31]}}, m} : {32'd0, m};
        es = u ? {{32{s[31]}}, s} : {32'd0, s};
        return em * es + (a ? acc : 64'd0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            rem = 0;
            exp_done = 0;
        end else if (rem == 0) begin
            exp_done = 0;
            if (start) begin
                exp_res = model(op_m, op_s, {acc_hi, acc_lo}, instr[22], instr[21]);
                exp_idx = instr[19:12];
                exp_s   = instr[20];
                exp_tag = op_tag;
                rem     = ITERS + 1;
            end
        end else begin
            rem = rem - 1;
            exp_done = (rem == 0);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R9", {63'd0, done}, {63'd0, exp_done});
            if (exp_done) begin
                check({exp_tag, "/R5"}, {res_hi, res_lo}, exp_res);
                check("R1", {56'd0, dst_hi, dst_lo}, {56'd0, exp_idx});
                check("R8", {63'd0, flag_wr}, {63'd0, exp_s});
                if (exp_s) begin
                    check("R6", {63'd0, flag_z}, {63'd0, exp_res == 64'd0});
                    check("R7", {63'd0, flag_n}, {63'd0, exp_res[63]});
                end
            end else begin
                check("R8", {63'd0, flag_wr}, 64'd0);
            end
        end
    end

    function automatic logic [31:0] mk(input bit u, input bit a, input bit s,
                                       input logic [3:0] hi, input logic [3:0] lo);
        return {9'h15A, u, a, s, hi, lo, 12'h9C3};
    endfunction

    task automatic run_op(input logic [31:0] m, input logic [31:0] s, input logic [31:0] ah,
                          input logic [31:0] al, input logic [31:0] ins, input string tag);
        @(negedge clk);
        op_m = m; op_s = s; acc_hi = ah; acc_lo = al; instr = ins; op_tag = tag;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (rem != 0) @(negedge clk);
    endtask

    function automatic string tag_of(input bit u, input bit a);
        return a ? "R4" : (u ? "R3" : "R2");
    endfunction

    logic [31:0] corner [5] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11", {62'd0, done, flag_wr}, 64'd0);
        check("R11", {res_hi, res_lo}, 64'd0);
        check("R11", {56'd0, dst_hi, dst_lo}, 64'd0);

        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                for (int c = 0; c < 4; c++)
                    run_op(corner[i], corner[j], corner[(i + 1) % 5], corner[j],
                           mk(c[0], c[1], (i + j + c) % 3 != 0, 4'(i + c), 4'(j + 7)),
                           tag_of(c[0], c[1]));

        // explicit boundary cases
        run_op(32'hFFFFFFFF, 32'h1, 32'h0, 32'h1, mk(1, 1, 1, 4'd2, 4'd3), "R6");
        run_op(32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, mk(0, 1, 1, 4'd4, 4'd5), "R4");
        run_op(32'hFFFFFFFF, 32'h1, 32'h0, 32'h0, mk(1, 0, 1, 4'd15, 4'd0), "R7");
        run_op(32'h80000000, 32'h80000000, 32'h0, 32'h0, mk(1, 0, 1, 4'd1, 4'd6), "R3");
        run_op(32'h12345678, 32'h9ABCDEF0, 32'h0, 32'h0, mk(0, 0, 0, 4'd9, 4'd8), "R8");

        for (int k = 0; k < 150; k++) begin
            logic [31:0] w;
            w = $urandom;
            run_op($urandom, $urandom, $urandom, $urandom,
                   mk(w[0], w[1], w[2], w[7:4], w[11:8]), tag_of(w[0], w[1]));
        end

        // R10: start pulse while busy is ignored
        @(negedge clk);
        op_m = 32'hDEADBEEF; op_s = 32'h00C0FFEE; acc_hi = 32'h1; acc_lo = 32'h2;
        instr = mk(1, 1, 1, 4'd11, 4'd12); op_tag = "R10";
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        op_m = 32'h0; op_s = 32'h0; instr = mk(0, 0, 0, 4'd1, 4'd1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (rem != 0) @(negedge clk);
        repeat (4) @(negedge clk);

        // R9: start held high, re-accepted right after each done
        op_m = 32'h0000FFFF; op_s = 32'hFFFF0000; instr = mk(0, 0, 1, 4'd3, 4'd4); op_tag = "R9";
        start = 1'b1;
        repeat (3 * (ITERS + 2) + 1) @(negedge clk);
        start = 1'b0;
        while (rem != 0) @(negedge clk);
        repeat (3) @(negedge clk);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule